// File: doc/BRIEF.md
# Counting Semaphore Command Engine

This block owns a bank of 32 counting semaphores, each 12 bits wide, and executes semaphore commands that travel with DMA requests. A request carries up to four 32-bit command words. The request sequencer hands the block each word twice: once during the pre-transfer pass and once during the post-transfer pass. Each word states which pass it belongs to. On the other pass the block retires it at once and does nothing else. Commands arrive one at a time on a valid/ready handshake, and the block pulses `done` when each one retires.

A command can set, raise or lower a semaphore. It can also stall until a semaphore equals a value or reaches at least a value. A take operation stalls until the semaphore is positive and then decrements it in the same cycle that it passes. Two optional fences hold any command back until the outstanding to-device transfer count or the outstanding from-device transfer count drains to zero. A stalled command re-checks its condition every cycle. A separate increment port lets another agent release waiters. A combinational peek port shows the value of any semaphore.

Top module: `sem_cmd_unit`

## Requirements
- R1: After reset every semaphore reads 0, `cmd_ready` is 1, and `done` and `done_err` are 0.
- R2: A word is taken on a clock edge where `cmd_valid` and `cmd_ready` are both 1. `cmd_ready` then stays 0 until the command retires. Retirement shows as a one-cycle `done` pulse in the cycle after the retiring edge, and `cmd_ready` returns to 1 in that same cycle.
- R3: A word with bit 31 clear retires on the first edge after it is accepted and has no effect.
- R4: Bit 22 gives the word's pass: 1 means pre-transfer and 0 means post-transfer. The block compares it with `cmd_presync` as sampled at acceptance. On a mismatch the word retires with no effect.
- R5: Bits [26:24] are the opcode, bits [20:16] select the semaphore and bits [11:0] are the operand. Opcode 0 retires with no change. Opcode 1 loads the operand into the semaphore.
- R6: Opcode 2 adds one, holding at 4095. Opcode 3 subtracts one, holding at 0.
- R7: Opcode 4 stalls until the semaphore equals the operand. Opcode 5 stalls until the semaphore is greater than or equal to the operand. The condition is re-evaluated every cycle.
- R8: Opcode 6 stalls while the semaphore is 0. It retires on the first edge where the semaphore is positive, and on that edge it decrements the semaphore by one.
- R9: When bit 30 is set, an enabled word on its matching pass stalls while `todev_pending` is nonzero. When bit 29 is set, it stalls while `fromdev_pending` is nonzero.
- R10: An enabled, pass-matching word with opcode 7 retires with `done_err` set alongside `done`, and has no effect.
- R11: `cmd_first` marks the first word of a request. Within one request, a second enabled word that has bit 22 set and is accepted in the pre-transfer pass retires with `done_err` and has no effect.
- R12: `inc_valid` adds one to semaphore `inc_idx`, holding at 4095. On an edge where a command also writes that semaphore, the increment applies on top of the command's result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command word offered |
| cmd_ready | output | 1 | Block can take a word |
| cmd_word | input | 32 | Semaphore command word |
| cmd_first | input | 1 | Word is the first of a new request |
| cmd_presync | input | 1 | Current pass: 1 pre-transfer, 0 post-transfer |
| todev_pending | input | CNT_W | Outstanding to-device transfers |
| fromdev_pending | input | CNT_W | Outstanding from-device transfers |
| inc_valid | input | 1 | External increment strobe |
| inc_idx | input | 5 | Semaphore to increment |
| peek_idx | input | 5 | Semaphore to observe |
| peek_val | output | 12 | Value of semaphore `peek_idx` |
| done | output | 1 | A command retired on the previous edge |
| done_err | output | 1 | The retired command was rejected |

## Verification
A corrupted semaphore value shows on `peek_val` one cycle after the faulty edge. It also changes when a later wait or take command retires, so `done` is early, late or missing. A wrong busy or phase register shows at once as a `cmd_ready` or `done` pattern that differs from the reference. A lost duplicate-presync flag shows as a missing `done_err` on the cycle the second word retires. The bench compares the handshake, both retirement outputs and the watched semaphore with a behavioural model on every clock, so any divergence is caught within one cycle of reaching a port.

// File: rtl/sem_pkg.sv
package sem_pkg;
  localparam int SEM_N = 32;
  localparam int IDX_W = $clog2(SEM_N);
  localparam int VAL_W = 12;

  typedef enum logic [2:0] {
    OP_NOP  = 3'd0,
    OP_SET  = 3'd1,
    OP_UP   = 3'd2,
    OP_DOWN = 3'd3,
    OP_WEQ  = 3'd4,
    OP_WGE  = 3'd5,
    OP_TAKE = 3'd6,
    OP_RSV  = 3'd7
  } sem_op_e;

  typedef struct packed {
    logic             en;
    logic             fence_td;
    logic             fence_fd;
    sem_op_e          op;
    logic             pre;
    logic [IDX_W-1:0] idx;
    logic [VAL_W-1:0] arg;
  } sem_cmd_t;

  function automatic sem_cmd_t decode_cmd(input logic [31:0] w);
    sem_cmd_t c;
    c.en       = w[31];
    c.fence_td = w[30];
    c.fence_fd = w[29];
    c.op       = sem_op_e'(w[26:24]);
    c.pre      = w[22];
    c.idx      = w[16 +: IDX_W];
    c.arg      = w[VAL_W-1:0];
    return c;
  endfunction

  function automatic logic [VAL_W-1:0] sat_inc(input logic [VAL_W-1:0] v);
    return (v == {VAL_W{1'b1}}) ? v : v + 1'b1;
  endfunction

  function automatic logic [VAL_W-1:0] sat_dec(input logic [VAL_W-1:0] v);
    return (v == '0) ? v : v - 1'b1;
  endfunction
endpackage

// File: rtl/sem_bank.sv
module sem_bank
  import sem_pkg::*;
#(
  parameter int N = SEM_N,
  parameter int W = VAL_W,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [W-1:0]  wr_data,
  input  logic          inc_en,
  input  logic [IW-1:0] inc_idx,
  input  logic [IW-1:0] rd_a_idx,
  output logic [W-1:0]  rd_a_val,
  input  logic [IW-1:0] rd_b_idx,
  output logic [W-1:0]  rd_b_val
);
  logic [W-1:0] sem_q [N];
  logic [W-1:0] sem_d [N];

  for (genvar i = 0; i < N; i++) begin : g_entry
    logic [W-1:0] after_wr;
    always_comb begin
      after_wr = (wr_en && wr_idx == IW'(i)) ? wr_data : sem_q[i];
      sem_d[i] = (inc_en && inc_idx == IW'(i)) ? sat_inc(after_wr) : after_wr;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sem_q[i] <= '0;
      else        sem_q[i] <= sem_d[i];
    end
  end

  assign rd_a_val = sem_q[rd_a_idx];
  assign rd_b_val = sem_q[rd_b_idx];
endmodule

// File: rtl/sem_ctrl.sv
module sem_ctrl
  import sem_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  input  logic [31:0] cmd_word,
  input  logic        cmd_first,
  input  logic        cmd_presync,
  input  logic        fire,
  input  logic        fire_err,
  output logic        busy,
  output sem_cmd_t    held,
  output logic        phase_q,
  output logic        dup_q,
  output logic        done,
  output logic        done_err
);
  logic     seen_q;
  logic     seen_base;
  logic     is_pre;
  sem_cmd_t incoming;

  always_comb begin
    incoming  = decode_cmd(cmd_word);
    seen_base = cmd_first ? 1'b0 : seen_q;
    is_pre    = incoming.en && incoming.pre && cmd_presync;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      held     <= '0;
      phase_q  <= 1'b0;
      dup_q    <= 1'b0;
      seen_q   <= 1'b0;
      done     <= 1'b0;
      done_err <= 1'b0;
    end else begin
      done     <= fire;
      done_err <= fire && fire_err;
      if (busy) begin
        if (fire) busy <= 1'b0;
      end else if (cmd_valid) begin
        busy    <= 1'b1;
        held    <= incoming;
        phase_q <= cmd_presync;
        dup_q   <= is_pre && seen_base;
        seen_q  <= seen_base || is_pre;
      end
    end
  end
endmodule

// File: rtl/sem_eval.sv
module sem_eval
  import sem_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             busy,
  input  sem_cmd_t         held,
  input  logic             phase_q,
  input  logic             dup_q,
  input  logic [VAL_W-1:0] cur_val,
  input  logic [CNT_W-1:0] todev_cnt,
  input  logic [CNT_W-1:0] fromdev_cnt,
  output logic             fire,
  output logic             fire_err,
  output logic             wr_en,
  output logic [VAL_W-1:0] wr_data,
  output logic             ev_take,
  output logic             ev_weq,
  output logic             ev_wge,
  output logic             ev_fence_td,
  output logic             ev_fence_fd
);
  logic live;
  logic blocked;

  always_comb begin
    live    = held.en && (held.pre == phase_q);
    blocked = (held.fence_td && todev_cnt != '0) ||
              (held.fence_fd && fromdev_cnt != '0);
    fire     = 1'b0;
    fire_err = 1'b0;
    wr_en    = 1'b0;
    wr_data  = cur_val;
    if (busy) begin
      if (!live) begin
        fire = 1'b1;
      end else if (dup_q || held.op == OP_RSV) begin
        fire     = 1'b1;
        fire_err = 1'b1;
      end else if (!blocked) begin
        case (held.op)
          OP_NOP:  fire = 1'b1;
          OP_SET:  begin fire = 1'b1; wr_en = 1'b1; wr_data = held.arg; end
          OP_UP:   begin fire = 1'b1; wr_en = 1'b1; wr_data = sat_inc(cur_val); end
          OP_DOWN: begin fire = 1'b1; wr_en = 1'b1; wr_data = sat_dec(cur_val); end
          OP_WEQ:  fire = (cur_val == held.arg);
          OP_WGE:  fire = (cur_val >= held.arg);
          OP_TAKE: begin
            fire    = (cur_val != '0);
            wr_en   = fire;
            wr_data = cur_val - 1'b1;
          end
          default: fire = 1'b1;
        endcase
      end
    end
  end

  assign ev_take     = fire && live && !fire_err && held.op == OP_TAKE;
  assign ev_weq      = fire && live && !fire_err && held.op == OP_WEQ;
  assign ev_wge      = fire && live && !fire_err && held.op == OP_WGE;
  assign ev_fence_td = fire && live && !fire_err && held.fence_td;
  assign ev_fence_fd = fire && live && !fire_err && held.fence_fd;
endmodule

// File: rtl/sem_cmd_unit.sv
module sem_cmd_unit
  import sem_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [31:0]      cmd_word,
  input  logic             cmd_first,
  input  logic             cmd_presync,
  input  logic [CNT_W-1:0] todev_pending,
  input  logic [CNT_W-1:0] fromdev_pending,
  input  logic             inc_valid,
  input  logic [IDX_W-1:0] inc_idx,
  input  logic [IDX_W-1:0] peek_idx,
  output logic [VAL_W-1:0] peek_val,
  output logic             done,
  output logic             done_err
);
  logic             busy;
  sem_cmd_t         held;
  logic             phase_q;
  logic             dup_q;
  logic             fire;
  logic             fire_err;
  logic             wr_en;
  logic [VAL_W-1:0] wr_data;
  logic [VAL_W-1:0] sel_val;
  logic             ev_take;
  logic             ev_weq;
  logic             ev_wge;
  logic             ev_fence_td;
  logic             ev_fence_fd;

  assign cmd_ready = !busy;

  sem_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
    .cmd_first(cmd_first), .cmd_presync(cmd_presync), .fire(fire),
    .fire_err(fire_err), .busy(busy), .held(held), .phase_q(phase_q),
    .dup_q(dup_q), .done(done), .done_err(done_err)
  );

  sem_eval #(.CNT_W(CNT_W)) u_eval (
    .busy(busy), .held(held), .phase_q(phase_q), .dup_q(dup_q),
    .cur_val(sel_val), .todev_cnt(todev_pending), .fromdev_cnt(fromdev_pending),
    .fire(fire), .fire_err(fire_err), .wr_en(wr_en), .wr_data(wr_data),
    .ev_take(ev_take), .ev_weq(ev_weq), .ev_wge(ev_wge),
    .ev_fence_td(ev_fence_td), .ev_fence_fd(ev_fence_fd)
  );

  sem_bank #(.N(SEM_N), .W(VAL_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(held.idx),
    .wr_data(wr_data), .inc_en(inc_valid), .inc_idx(inc_idx),
    .rd_a_idx(held.idx), .rd_a_val(sel_val),
    .rd_b_idx(peek_idx), .rd_b_val(peek_val)
  );
endmodule

// File: rtl/sem_cmd_checker.sv
module sem_cmd_checker
  import sem_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_valid,
  input logic             cmd_ready,
  input logic             done,
  input logic             done_err,
  input logic             ev_take,
  input logic             ev_weq,
  input logic             ev_wge,
  input logic             ev_fence_td,
  input logic             ev_fence_fd,
  input logic [VAL_W-1:0] sel_val,
  input logic [VAL_W-1:0] held_arg,
  input logic [CNT_W-1:0] todev_pending,
  input logic [CNT_W-1:0] fromdev_pending
);
  assert_done_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_accept_blocks_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> !cmd_ready);
  assert_ready_after_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> cmd_ready);
  assert_weq_match_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_weq |-> sel_val == held_arg);
  assert_wge_match_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wge |-> sel_val >= held_arg);
  assert_take_positive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_take |-> sel_val != '0);
  assert_fence_td_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fence_td |-> todev_pending == '0);
  assert_fence_fd_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fence_fd |-> fromdev_pending == '0);
  assert_err_has_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done_err |-> done);
endmodule

bind sem_cmd_unit sem_cmd_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .done(done), .done_err(done_err), .ev_take(ev_take), .ev_weq(ev_weq),
  .ev_wge(ev_wge), .ev_fence_td(ev_fence_td), .ev_fence_fd(ev_fence_fd),
  .sel_val(sel_val), .held_arg(held.arg), .todev_pending(todev_pending),
  .fromdev_pending(fromdev_pending)
);

// File: tb/test_sem_cmd_unit.sv
module test_sem_cmd_unit;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 8;
  localparam int VMAX = 4095;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic          cmd_ready;
  logic [31:0]   cmd_word = '0;
  logic          cmd_first = 1'b0;
  logic          cmd_presync = 1'b0;
  logic [CW-1:0] todev_pending = '0;
  logic [CW-1:0] fromdev_pending = '0;
  logic          inc_valid = 1'b0;
  logic [4:0]    inc_idx = '0;
  logic [4:0]    peek_idx = '0;
  logic [11:0]   peek_val;
  logic          done;
  logic          done_err;

  sem_cmd_unit #(.CNT_W(CW)) i_sem_cmd_unit (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_word(cmd_word), .cmd_first(cmd_first), .cmd_presync(cmd_presync),
    .todev_pending(todev_pending), .fromdev_pending(fromdev_pending),
    .inc_valid(inc_valid), .inc_idx(inc_idx), .peek_idx(peek_idx),
    .peek_val(peek_val), .done(done), .done_err(done_err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int    vectors = 0;
  int    miscompares = 0;
  int    cycles = 0;
  string cur_req = "R1";

  // behavioural reference state
  int          m_sem [32];
  bit          m_busy, m_done, m_err, m_seen, m_dup, m_phase;
  logic [31:0] m_cmd;
  int          n_sem [32];
  bit          n_busy, n_done, n_err, fin, base, pre;
  int          op, ix, arg, cv;

  function automatic logic [31:0] mk(bit en, bit ftd, bit ffd, int opc,
                                     bit ps, int idx, int val);
    logic [31:0] w = '0;
    w[31] = en; w[30] = ftd; w[29] = ffd;
    w[26:24] = opc[2:0]; w[22] = ps;
    w[20:16] = idx[4:0]; w[11:0] = val[11:0];
    return w;
  endfunction

  task automatic compare(string what, int act, int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %0d expected %0d", cur_req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  always @(negedge clk) begin
    cycles++;
    if (!rst_n) begin
      foreach (m_sem[i]) m_sem[i] = 0;
      m_busy = 0; m_done = 0; m_err = 0; m_seen = 0; m_dup = 0; m_phase = 0;
      m_cmd = '0;
    end
    compare("ready", int'(cmd_ready), int'(!m_busy));
    compare("done", int'(done), int'(m_done));
    compare("done_err", int'(done_err), int'(m_err));
    compare("peek", int'(peek_val), m_sem[peek_idx]);
    if (rst_n) begin
      n_sem = m_sem; n_busy = m_busy; n_done = 0; n_err = 0;
      if (m_busy) begin
        op = int'(m_cmd[26:24]); ix = int'(m_cmd[20:16]); arg = int'(m_cmd[11:0]);
        cv = m_sem[ix]; fin = 0;
        if (!m_cmd[31] || m_cmd[22] != m_phase) fin = 1;
        else if (m_dup || op == 7) begin fin = 1; n_err = 1; end
        else if ((m_cmd[30] && todev_pending != 0) || (m_cmd[29] && fromdev_pending != 0)) fin = 0;
        else begin
          case (op)
            0: fin = 1;
            1: begin n_sem[ix] = arg; fin = 1; end
            2: begin n_sem[ix] = (cv < VMAX) ? cv + 1 : VMAX; fin = 1; end
            3: begin n_sem[ix] = (cv > 0) ? cv - 1 : 0; fin = 1; end
            4: fin = (cv == arg);
            5: fin = (cv >= arg);
            6: if (cv > 0) begin n_sem[ix] = cv - 1; fin = 1; end
            default: fin = 1;
          endcase
        end
        if (fin) begin n_done = 1; n_busy = 0; end
      end else if (cmd_valid) begin
        n_busy = 1; m_cmd = cmd_word; m_phase = cmd_presync;
        base = cmd_first ? 0 : m_seen;
        pre = cmd_word[31] && cmd_word[22] && cmd_presync;
        m_dup = pre && base;
        m_seen = base || pre;
      end
      if (inc_valid)
        n_sem[inc_idx] = (n_sem[inc_idx] < VMAX) ? n_sem[inc_idx] + 1 : VMAX;
      m_sem = n_sem; m_busy = n_busy; m_done = n_done; m_err = n_err;
    end
    if (cycles > 20000) begin
      miscompares++;
      $display("FAIL watchdog: actual %0d cycles expected under 20000", cycles);
      finish_run();
    end
  end

  task automatic issue(logic [31:0] w, bit first);
    bit r;
    cmd_valid = 1'b1; cmd_word = w; cmd_first = first;
    for (int k = 0; k < 200; k++) begin
      @(negedge clk) r = cmd_ready;
      @(posedge clk) #1;
      if (r) break;
    end
    cmd_valid = 1'b0; cmd_first = 1'b0;
  endtask

  task automatic wait_done();
    for (int k = 0; k < 60; k++) begin
      @(negedge clk);
      if (done) break;
    end
    @(posedge clk) #1;
  endtask

  task automatic bump(int idx);
    inc_valid = 1'b1; inc_idx = idx[4:0];
    @(posedge clk) #1;
    inc_valid = 1'b0;
  endtask

  task automatic run(logic [31:0] w, bit first);
    issue(w, first);
    wait_done();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk) #1;

    cur_req = "R5"; peek_idx = 5'd3;
    run(mk(1,0,0,1,0,3,5), 1);
    run(mk(1,0,0,0,0,3,9), 0);
    cur_req = "R6";
    run(mk(1,0,0,2,0,3,0), 0);
    run(mk(1,0,0,3,0,3,0), 0);
    peek_idx = 5'd4;
    run(mk(1,0,0,3,0,4,0), 1);
    run(mk(1,0,0,1,0,4,4095), 0);
    run(mk(1,0,0,2,0,4,0), 0);

    cur_req = "R3"; peek_idx = 5'd3;
    run(mk(0,0,0,1,0,3,9), 1);
    cur_req = "R4";
    run(mk(1,0,0,1,1,3,8), 1);
    cmd_presync = 1'b1;
    run(mk(1,0,0,1,1,3,7), 1);
    run(mk(1,0,0,1,0,3,2), 0);

    cur_req = "R11";
    run(mk(1,0,0,1,1,3,1), 1);
    run(mk(1,0,0,1,1,3,2), 0);
    run(mk(1,0,0,1,1,3,6), 1);
    cmd_presync = 1'b0;

    cur_req = "R10";
    run(mk(1,0,0,7,0,3,0), 1);

    cur_req = "R7"; peek_idx = 5'd6;
    issue(mk(1,0,0,4,0,6,2), 1);
    repeat (5) @(posedge clk);
    #1 bump(6);
    repeat (3) @(posedge clk);
    #1 bump(6);
    wait_done();
    run(mk(1,0,0,5,0,6,1), 0);
    issue(mk(1,0,0,5,0,6,4), 0);
    repeat (4) @(posedge clk);
    #1 bump(6);
    bump(6);
    wait_done();

    cur_req = "R8"; peek_idx = 5'd7;
    issue(mk(1,0,0,6,0,7,0), 1);
    repeat (6) @(posedge clk);
    #1 bump(7);
    wait_done();
    run(mk(1,0,0,1,0,7,1), 0);
    run(mk(1,0,0,6,0,7,0), 0);

    cur_req = "R12"; peek_idx = 5'd8;
    run(mk(1,0,0,1,0,8,4095), 1);
    bump(8);
    repeat (2) @(posedge clk);
    #1 peek_idx = 5'd9;
    issue(mk(1,0,0,1,0,9,10), 0);
    inc_valid = 1'b1; inc_idx = 5'd9;
    @(posedge clk) #1;
    inc_valid = 1'b0;
    wait_done();

    cur_req = "R9"; peek_idx = 5'd9;
    todev_pending = 8'd3;
    issue(mk(1,1,0,2,0,9,0), 1);
    repeat (5) @(posedge clk);
    #1 todev_pending = 8'd0;
    wait_done();
    fromdev_pending = 8'd2;
    issue(mk(1,0,1,2,0,9,0), 0);
    repeat (4) @(posedge clk);
    #1 fromdev_pending = 8'd0;
    wait_done();
    fromdev_pending = 8'd5;
    run(mk(1,1,0,3,0,9,0), 0);
    fromdev_pending = 8'd0;

    cur_req = "R2";
    for (int k = 0; k < 4; k++) issue(mk(1,0,0,2,0,10,0), k == 0);
    wait_done();

    repeat (3) @(posedge clk);
    finish_run();
  end
endmodule